// File: doc/BRIEF.md
# Banked Working Register File with Width-Selectable File Exchange

This block stores the working registers of an 8-bit-heritage CPU core whose register pairs have been widened to 32 bits. It holds four independent banks, and a bank select register picks the one that all accesses use. Every bank has two files, a primary and an alternate. Each file contains an accumulator A, a flag byte F and the three pairs BC, DE and HL. Each pair has a 16-bit low half, whose bytes are also named B/C, D/E and H/L, and a 16-bit upper extension. HL serves as the word accumulator for the datapath. Every bank also holds four 32-bit index registers. The two bytes of each index register's low 16 bits can be read and written one at a time.

Instruction decode drives the block through a register-address write port, two combinational read ports and a set of strobes. The file exchange swaps the roles of the active and alternate files in a single clock. How much of each pair takes part depends on the data mode. In Word mode only the low 16 bits trade places and the upper extensions stay with their role. In Long Word mode all 32 bits trade places. The mode comes from a global bit. A one-shot override can replace that bit for the next instruction only.

Register address `addr[5:0]`: when bit 5 = 0 the address names a file register. Bit 4 selects the file role (0 = active, 1 = alternate). Bits 3:0 give the register: 0 A, 1 F, 2 B, 3 C, 4 D, 5 E, 6 H, 7 L, 8 BC, 9 DE, 10 HL. When bit 5 = 1 the address names an index register. Bits 1:0 give the index register (0 IX, 1 IX', 2 IY, 3 IY'), bit 2 must be 0, and bits 4:3 give the view: 0 all 32 bits, 1 bits 15:8, 2 bits 7:0.

Top module: `xreg_file`

## Requirements
- R1: After rst_ni is asserted, every register in every bank reads 0, bank_o is 0, the primary file is the active one, Word mode is in force (long_mode_o = 0), and no override is pending.
- R2: A cycle with sel_we_i high loads sel_bank_i into the bank select register, and bank_o shows the new value from the next cycle on. Reads, writes and exchanges in that cycle still use the old bank. Each bank keeps its contents while it is not selected.
- R3: Both read ports return the addressed register of the selected bank combinationally, following the address map. Byte registers read zero-extended. Reserved addresses (file codes 11 to 15, index addresses with bit 2 = 1 or view 3) read 0, and writing them changes nothing.
- R4: B, C, D, E, H and L are the high and low bytes of bits 15:0 of BC, DE and HL. Writing a byte changes only that byte. A pair write loads all 32 bits.
- R5: Index registers can be written and read as 32 bits, as bits 15:8 or as bits 7:0. A byte write leaves the other 24 bits unchanged.
- R6: Registers of the alternate file can be read and written through address bit 4 = 1 without an exchange.
- R7: A cycle with xchg_i high swaps the roles of the active and alternate files of the selected bank, with A and F always swapped whole. The index registers do not take part.
- R8: In Word mode the exchange swaps only bits 15:0 of BC, DE and HL between the files. The upper 16 bits of each pair stay with their role.
- R9: In Long Word mode the exchange swaps all 32 bits of BC, DE and HL.
- R10: set_long_i selects Long Word mode and set_word_i selects Word mode globally, from the next cycle on. If both are high in the same cycle, Long Word mode wins.
- R11: ovr_i arms a one-shot mode equal to ovr_long_i. The one-shot mode applies until the next exchange or insn_end_i, whichever comes first, and that event clears it. When ovr_i and xchg_i are high in the same cycle, the exchange uses ovr_long_i and nothing stays armed. long_mode_o always shows the effective mode: the override in the current cycle first, then the armed one-shot, then the global bit.
- R12: When a write and an exchange fall in the same cycle, the exchange is applied first. The write's role bit then refers to the files as they stand after the exchange.
- R13: F stores all 8 bits as written. The flag layout is sign 7, zero 6, half carry 4, parity/overflow 2, add/subtract 1, carry 0. Bits 5 and 3 are stored as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_we_i | input | 1 | Load the bank select register |
| sel_bank_i | input | 2 | New bank number |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 6 | Register address for the write |
| wr_data_i | input | 32 | Write data (bytes use bits 7:0) |
| rd_a_addr_i | input | 6 | Read port A address |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 6 | Read port B address |
| rd_b_data_o | output | 32 | Read port B data |
| xchg_i | input | 1 | Exchange active and alternate files |
| set_word_i | input | 1 | Select Word mode globally |
| set_long_i | input | 1 | Select Long Word mode globally |
| ovr_i | input | 1 | One-shot mode override strobe |
| ovr_long_i | input | 1 | Mode forced by the override (1 = Long Word) |
| insn_end_i | input | 1 | Instruction boundary, ends an armed override |
| bank_o | output | 2 | Currently selected bank |
| long_mode_o | output | 1 | Effective data mode this cycle |

## Verification
The hardest case to reach is an exchange whose mode comes from an armed one-shot override that disagrees with the global bit, in a cycle that also carries a write to the active file. The exchange has to happen in the override's mode, and the write has to land in the file that has just become active. Directed sequences build this up step by step. First they load different upper and lower halves into both files. Then they arm an override against the global mode, and then they issue the exchange together with a pair write. A long random phase follows that mixes overrides, instruction-end strobes, bank switches and same-cycle write-with-exchange, and it checks every cycle against a model that physically moves data between the two files.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int DW     = 32;
  localparam int AW     = 6;
  localparam int NPAIR  = 3;
  localparam int NIDX   = 4;

  // file register codes (addr[3:0] when addr[5] = 0)
  localparam logic [3:0] C_A  = 4'd0;
  localparam logic [3:0] C_F  = 4'd1;
  localparam logic [3:0] C_B  = 4'd2;
  localparam logic [3:0] C_C  = 4'd3;
  localparam logic [3:0] C_D  = 4'd4;
  localparam logic [3:0] C_E  = 4'd5;
  localparam logic [3:0] C_H  = 4'd6;
  localparam logic [3:0] C_L  = 4'd7;
  localparam logic [3:0] C_BC = 4'd8;
  localparam logic [3:0] C_DE = 4'd9;
  localparam logic [3:0] C_HL = 4'd10;

  typedef enum logic [1:0] {
    IV_FULL = 2'd0,
    IV_HI   = 2'd1,
    IV_LO   = 2'd2,
    IV_RSV  = 2'd3
  } idx_view_e;
endpackage

// File: rtl/xreg_mode.sv
module xreg_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_word_i,
  input  logic set_long_i,
  input  logic ovr_i,
  input  logic ovr_long_i,
  input  logic xchg_i,
  input  logic insn_end_i,
  output logic long_o
);
  logic glob_q, pend_q, pend_long_q;

  assign long_o = ovr_i ? ovr_long_i : (pend_q ? pend_long_q : glob_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glob_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_long_q <= 1'b0;
    end else begin
      if (set_long_i)      glob_q <= 1'b1;
      else if (set_word_i) glob_q <= 1'b0;
      if (ovr_i && !xchg_i) begin
        pend_q      <= 1'b1;
        pend_long_q <= ovr_long_i;
      end else if (xchg_i || insn_end_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_ovr_consumed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i |=> !pend_q);
  assert_glob_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_word_i || set_long_i) |=> $stable(glob_q));
  assert_long_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_long_i |=> glob_q);
endmodule

// File: rtl/xreg_bank.sv
module xreg_bank
  import xreg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          xchg_i,
  input  logic          long_i,
  input  logic [AW-1:0] rd_a_addr_i,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  output logic [DW-1:0] rd_b_data_o
);
  localparam int HW = DW / 2;

  logic [1:0][7:0]            a_q, a_d, f_q, f_d;
  logic [1:0][NPAIR-1:0][HW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [NIDX-1:0][DW-1:0]    ix_q, ix_d;
  logic                       act_q, act_d;
  logic                       wp;
  logic [1:0]                 wk;

  // physical file index = act ^ role; hi halves swap in Word mode to stay with role
  always_comb begin
    a_d = a_q; f_d = f_q; lo_d = lo_q; hi_d = hi_q; ix_d = ix_q; act_d = act_q;
    if (xchg_i) begin
      act_d = ~act_q;
      if (!long_i) begin
        hi_d[0] = hi_q[1];
        hi_d[1] = hi_q[0];
      end
    end
    wp = act_d ^ wr_addr_i[4];
    wk = 2'd0;
    if (wr_en_i) begin
      if (!wr_addr_i[5]) begin
        unique case (wr_addr_i[3:0])
          C_A: a_d[wp] = wr_data_i[7:0];
          C_F: f_d[wp] = wr_data_i[7:0];
          C_B, C_C, C_D, C_E, C_H, C_L: begin
            wk = wr_addr_i[2:1] - 2'd1;
            if (wr_addr_i[0]) lo_d[wp][wk][7:0]  = wr_data_i[7:0];
            else              lo_d[wp][wk][15:8] = wr_data_i[7:0];
          end
          C_BC, C_DE, C_HL: begin
            wk = wr_addr_i[1:0];
            {hi_d[wp][wk], lo_d[wp][wk]} = wr_data_i;
          end
          default: ;
        endcase
      end else if (!wr_addr_i[2]) begin
        unique case (idx_view_e'(wr_addr_i[4:3]))
          IV_FULL: ix_d[wr_addr_i[1:0]]       = wr_data_i;
          IV_HI:   ix_d[wr_addr_i[1:0]][15:8] = wr_data_i[7:0];
          IV_LO:   ix_d[wr_addr_i[1:0]][7:0]  = wr_data_i[7:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; f_q <= '0; lo_q <= '0; hi_q <= '0; ix_q <= '0; act_q <= 1'b0;
    end else begin
      a_q <= a_d; f_q <= f_d; lo_q <= lo_d; hi_q <= hi_d; ix_q <= ix_d; act_q <= act_d;
    end
  end

  function automatic logic [DW-1:0] rd_reg(input logic [AW-1:0] ad);
    logic       p;
    logic [1:0] k;
    p = act_q ^ ad[4];
    rd_reg = '0;
    if (!ad[5]) begin
      unique case (ad[3:0])
        C_A: rd_reg = {24'd0, a_q[p]};
        C_F: rd_reg = {24'd0, f_q[p]};
        C_B, C_C, C_D, C_E, C_H, C_L: begin
          k = ad[2:1] - 2'd1;
          rd_reg = {24'd0, ad[0] ? lo_q[p][k][7:0] : lo_q[p][k][15:8]};
        end
        C_BC, C_DE, C_HL: begin
          k = ad[1:0];
          rd_reg = {hi_q[p][k], lo_q[p][k]};
        end
        default: rd_reg = '0;
      endcase
    end else if (!ad[2]) begin
      unique case (idx_view_e'(ad[4:3]))
        IV_FULL: rd_reg = ix_q[ad[1:0]];
        IV_HI:   rd_reg = {24'd0, ix_q[ad[1:0]][15:8]};
        IV_LO:   rd_reg = {24'd0, ix_q[ad[1:0]][7:0]};
        default: rd_reg = '0;
      endcase
    end
  endfunction

  assign rd_a_data_o = rd_reg(rd_a_addr_i);
  assign rd_b_data_o = rd_reg(rd_b_addr_i);

  // role views for checks
  logic [HW-1:0] act_hi0;
  logic [DW-1:0] act_bc, alt_bc;
  assign act_hi0 = hi_q[act_q][0];
  assign act_bc  = {hi_q[act_q][0], lo_q[act_q][0]};
  assign alt_bc  = {hi_q[~act_q][0], lo_q[~act_q][0]};

  assert_xchg_toggle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xchg_i |=> act_q != $past(act_q));
  assert_idx_untouched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_i && !wr_en_i) |=> $stable(ix_q));
  assert_word_hi_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_i && !long_i && !wr_en_i) |=> act_hi0 == $past(act_hi0));
  assert_long_swap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xchg_i && long_i && !wr_en_i) |=> act_bc == $past(alt_bc));
endmodule

// File: rtl/xreg_file.sv
module xreg_file
  import xreg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BW = $clog2(NUM_BANKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_we_i,
  input  logic [BW-1:0] sel_bank_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [DW-1:0] rd_a_data_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [DW-1:0] rd_b_data_o,
  input  logic          xchg_i,
  input  logic          set_word_i,
  input  logic          set_long_i,
  input  logic          ovr_i,
  input  logic          ovr_long_i,
  input  logic          insn_end_i,
  output logic [BW-1:0] bank_o,
  output logic          long_mode_o
);
  logic [BW-1:0] bank_q;
  logic          long_eff;
  logic [NUM_BANKS-1:0][DW-1:0] bk_rd_a, bk_rd_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (sel_we_i) bank_q <= sel_bank_i;
  end

  xreg_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_word_i (set_word_i),
    .set_long_i (set_long_i),
    .ovr_i      (ovr_i),
    .ovr_long_i (ovr_long_i),
    .xchg_i     (xchg_i),
    .insn_end_i (insn_end_i),
    .long_o     (long_eff)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank_q == BW'(b));
    xreg_bank u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en_i && hit),
      .wr_addr_i   (wr_addr_i),
      .wr_data_i   (wr_data_i),
      .xchg_i      (xchg_i && hit),
      .long_i      (long_eff),
      .rd_a_addr_i (rd_a_addr_i),
      .rd_b_addr_i (rd_b_addr_i),
      .rd_a_data_o (bk_rd_a[b]),
      .rd_b_data_o (bk_rd_b[b])
    );
  end

  assign rd_a_data_o = bk_rd_a[bank_q];
  assign rd_b_data_o = bk_rd_b[bank_q];
  assign bank_o      = bank_q;
  assign long_mode_o = long_eff;

  assert_bank_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(bank_q));
  assert_bank_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> bank_o == $past(sel_bank_i));
endmodule

// File: tb/xreg_file_tb.sv
module xreg_file_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_we_i = 0;
  logic [1:0]  sel_bank_i = 0;
  logic        wr_en_i = 0;
  logic [5:0]  wr_addr_i = 0;
  logic [31:0] wr_data_i = 0;
  logic [5:0]  rd_a_addr_i = 0, rd_b_addr_i = 0;
  logic [31:0] rd_a_data_o, rd_b_data_o;
  logic        xchg_i = 0, set_word_i = 0, set_long_i = 0;
  logic        ovr_i = 0, ovr_long_i = 0, insn_end_i = 0;
  logic [1:0]  bank_o;
  logic        long_mode_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xreg_file u_dut (.*);

  // reference model: data stored by role (0 active, 1 alternate), moved on exchange
  int          m_bank;
  bit          m_glong, m_pv, m_pl;
  logic [7:0]  m_a [4][2];
  logic [7:0]  m_f [4][2];
  logic [31:0] m_p [4][2][3];
  logic [31:0] m_x [4][4];

  task automatic model_reset();
    m_bank = 0; m_glong = 0; m_pv = 0; m_pl = 0;
    for (int b = 0; b < 4; b++) begin
      for (int r = 0; r < 2; r++) begin
        m_a[b][r] = 0; m_f[b][r] = 0;
        for (int k = 0; k < 3; k++) m_p[b][r][k] = 0;
      end
      for (int i = 0; i < 4; i++) m_x[b][i] = 0;
    end
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] ad);
    int r, c, i, v;
    r = ad[4]; c = int'(ad[3:0]);
    if (!ad[5]) begin
      if (c == 0) return {24'd0, m_a[m_bank][r]};
      if (c == 1) return {24'd0, m_f[m_bank][r]};
      if (c >= 2 && c <= 7)
        return (c % 2 == 0) ? {24'd0, m_p[m_bank][r][(c-2)/2][15:8]}
                            : {24'd0, m_p[m_bank][r][(c-2)/2][7:0]};
      if (c >= 8 && c <= 10) return m_p[m_bank][r][c-8];
      return 0;
    end
    if (ad[2]) return 0;
    i = int'(ad[1:0]); v = int'(ad[4:3]);
    if (v == 0) return m_x[m_bank][i];
    if (v == 1) return {24'd0, m_x[m_bank][i][15:8]};
    if (v == 2) return {24'd0, m_x[m_bank][i][7:0]};
    return 0;
  endfunction

  function automatic bit m_eff();
    return ovr_i ? ovr_long_i : (m_pv ? m_pl : m_glong);
  endfunction

  task automatic model_clock();
    int b, r, c, i, v;
    logic [7:0] t8;
    logic [31:0] t32;
    b = m_bank;
    if (xchg_i) begin
      t8 = m_a[b][0]; m_a[b][0] = m_a[b][1]; m_a[b][1] = t8;
      t8 = m_f[b][0]; m_f[b][0] = m_f[b][1]; m_f[b][1] = t8;
      for (int k = 0; k < 3; k++) begin
        t32 = m_p[b][0][k];
        if (m_eff()) begin
          m_p[b][0][k] = m_p[b][1][k]; m_p[b][1][k] = t32;
        end else begin
          m_p[b][0][k][15:0] = m_p[b][1][k][15:0]; m_p[b][1][k][15:0] = t32[15:0];
        end
      end
    end
    if (wr_en_i) begin
      r = wr_addr_i[4]; c = int'(wr_addr_i[3:0]);
      if (!wr_addr_i[5]) begin
        if (c == 0) m_a[b][r] = wr_data_i[7:0];
        else if (c == 1) m_f[b][r] = wr_data_i[7:0];
        else if (c >= 2 && c <= 7) begin
          if (c % 2 == 0) m_p[b][r][(c-2)/2][15:8] = wr_data_i[7:0];
          else            m_p[b][r][(c-2)/2][7:0]  = wr_data_i[7:0];
        end else if (c >= 8 && c <= 10) m_p[b][r][c-8] = wr_data_i;
      end else if (!wr_addr_i[2]) begin
        i = int'(wr_addr_i[1:0]); v = int'(wr_addr_i[4:3]);
        if (v == 0) m_x[b][i] = wr_data_i;
        else if (v == 1) m_x[b][i][15:8] = wr_data_i[7:0];
        else if (v == 2) m_x[b][i][7:0]  = wr_data_i[7:0];
      end
    end
    if (ovr_i && !xchg_i) begin m_pv = 1; m_pl = ovr_long_i; end
    else if (xchg_i || insn_end_i) m_pv = 0;
    if (set_long_i) m_glong = 1;
    else if (set_word_i) m_glong = 0;
    if (sel_we_i) m_bank = int'(sel_bank_i);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    check(req, "rd_a", rd_a_data_o, m_read(rd_a_addr_i));
    check(req, "rd_b", rd_b_data_o, m_read(rd_b_addr_i));
    check(req, "bank_o", {30'd0, bank_o}, m_bank);
    check(req, "long_mode_o", {31'd0, long_mode_o}, {31'd0, m_eff()});
  endtask

  // inputs set at negedge; compare, clock, update model, clear strobes
  task automatic step(input string req);
    #1;
    compare(req);
    @(posedge clk_i);
    model_clock();
    @(negedge clk_i);
    wr_en_i = 0; xchg_i = 0; set_word_i = 0; set_long_i = 0;
    ovr_i = 0; insn_end_i = 0; sel_we_i = 0;
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] d);
    wr_en_i = 1; wr_addr_i = ad; wr_data_i = d;
  endtask

  task automatic rd(input logic [5:0] a, input logic [5:0] b);
    rd_a_addr_i = a; rd_b_addr_i = b;
  endtask

  localparam logic [5:0] A_BC = 6'd8, A_DE = 6'd9, A_HL = 6'd10, A_A = 6'd0, A_F = 6'd1;
  localparam logic [5:0] ALT = 6'h10;

  task automatic load_both_files();
    wr(A_BC, 32'h1111_2222); step("R8");
    wr(A_DE, 32'h3333_4444); step("R8");
    wr(A_HL, 32'h5555_6666); step("R8");
    wr(A_A, 32'hA1);         step("R7");
    wr(ALT | A_BC, 32'h7777_8888); step("R6");
    wr(ALT | A_DE, 32'h9999_AAAA); step("R6");
    wr(ALT | A_HL, 32'hBBBB_CCCC); step("R6");
    wr(ALT | A_A, 32'hB2);         step("R6");
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
          errors++; checks++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    model_reset();
    // R1: reset state over the whole address space
    for (int ad = 0; ad < 64; ad++) begin
      rd(6'(ad), 6'(63 - ad));
      #1;
      compare("R1");
    end
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);

    // R3/R4: pair and byte aliasing
    wr(A_BC, 32'h1234_5678); rd(6'd2, 6'd3); step("R4");
    rd(6'd2, 6'd3); step("R4");
    wr(6'd2, 32'hFFFF_FFAA); rd(A_BC, 6'd3); step("R4");
    wr(6'd7, 32'h55); rd(A_HL, 6'd6); step("R4");
    wr(6'd13, 32'hDEAD_BEEF); rd(6'd13, 6'd15); step("R3");
    rd(A_BC, 6'd12); step("R3");
    // R13: flag byte incl. bits 5 and 3
    wr(A_F, 32'h0000_00FF); rd(A_F, A_A); step("R13");
    wr(A_F, 32'h0000_0028); rd(A_F, A_A); step("R13");
    rd(A_F, A_A); step("R13");
    // R5: index access
    wr(6'h20, 32'hCAFE_F00D); rd(6'h20, 6'h28); step("R5");
    wr(6'h29, 32'h12); rd(6'h21, 6'h29); step("R5");
    wr(6'h32, 32'h34); rd(6'h22, 6'h32); step("R5");
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, 6'h38); step("R3");
    wr(6'h3B, 32'hFF); rd(6'h23, 6'h3B); step("R3");
    rd(6'h22, 6'h20); step("R5");

    // R6/R8: word exchange
    load_both_files();
    rd(A_BC, ALT | A_BC); xchg_i = 1; step("R8");
    rd(A_BC, ALT | A_BC); step("R8");
    rd(A_HL, A_A); step("R7");
    rd(6'h20, ALT | A_DE); step("R7");
    // R10/R9: long exchange
    set_long_i = 1; set_word_i = 1; rd(A_BC, ALT | A_BC); step("R10");
    xchg_i = 1; rd(A_BC, ALT | A_BC); step("R9");
    rd(A_DE, ALT | A_HL); step("R9");
    set_word_i = 1; step("R10");
    rd(A_BC, A_HL); step("R10");
    // R11: armed override, then instruction end cancels it
    ovr_i = 1; ovr_long_i = 1; step("R11");
    insn_end_i = 1; rd(A_BC, ALT | A_BC); step("R11");
    xchg_i = 1; step("R11");
    rd(A_BC, ALT | A_BC); step("R11");
    ovr_i = 1; ovr_long_i = 1; step("R11");
    xchg_i = 1; rd(A_BC, ALT | A_BC); step("R11");
    rd(A_BC, ALT | A_BC); step("R11");
    ovr_i = 1; ovr_long_i = 1; xchg_i = 1; step("R11");
    rd(A_DE, ALT | A_DE); step("R11");
    // R12: override-armed long exchange with write to active pair
    ovr_i = 1; ovr_long_i = 1; step("R12");
    xchg_i = 1; wr(A_BC, 32'h0BAD_F00D); rd(A_BC, ALT | A_BC); step("R12");
    rd(A_BC, ALT | A_BC); step("R12");
    xchg_i = 1; wr(ALT | A_A, 32'h5A); rd(A_A, ALT | A_A); step("R12");
    rd(A_A, ALT | A_A); step("R12");

    // R2: bank switch, write in switch cycle lands in old bank
    sel_we_i = 1; sel_bank_i = 2; wr(A_HL, 32'h2222_0000); rd(A_HL, A_BC); step("R2");
    rd(A_HL, A_BC); step("R2");
    wr(A_HL, 32'h0000_2222); step("R2");
    sel_we_i = 1; sel_bank_i = 0; step("R2");
    rd(A_HL, A_BC); step("R2");
    sel_we_i = 1; sel_bank_i = 2; xchg_i = 1; step("R2");
    rd(A_HL, ALT | A_HL); step("R2");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      wr_en_i    = ($urandom % 2) == 0;
      wr_addr_i  = 6'($urandom);
      wr_data_i  = $urandom;
      rd_a_addr_i = ($urandom % 2) ? 6'($urandom % 11) : 6'($urandom);
      rd_b_addr_i = 6'($urandom);
      xchg_i     = ($urandom % 4) == 0;
      ovr_i      = ($urandom % 8) == 0;
      ovr_long_i = 1'($urandom);
      insn_end_i = ($urandom % 8) == 0;
      set_long_i = ($urandom % 16) == 0;
      set_word_i = ($urandom % 16) == 0;
      sel_we_i   = ($urandom % 16) == 0;
      sel_bank_i = 2'($urandom);
      step("R12");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule